// File: doc/BRIEF.md
# Scanline Fetch Scheduler with Address-Line-12 Counter

This block reproduces, dot by dot, the video memory fetch sequence a tile-based picture generator runs over one scanline. For the dot index it is given, it reports which kind of fetch is on the bus and the level of address line 12. Address line 12 is the bit that picks the lower or upper pattern page. It does not model pixel output, palette logic or a processor register interface.

Dots are counted from 1. Background tiles are fetched over dots 1 to 256. A dummy name-table fetch and a dummy attribute fetch then fill dots 257 to 260, so the first sprite pattern fetch starts at dot 261. Sprite fetch groups repeat every eight dots up to dot 320. The first two background tiles of the next line are fetched over dots 321 to 336, and dots 337 to 340 hold name-table reads. Name-table and attribute reads use the page at $2000, so address line 12 stays low during them. Pattern reads drive it from the page-select bit of the background or of the sprites.

An embedded counter is clocked by each rising edge of address line 12 and not by a line-start pulse. If the counter is zero when it is clocked, it reloads from a reload value; otherwise it decrements. The interrupt flag is set when a step leaves the counter at zero while interrupts are enabled.

Top module: `scanline_fetch_sched`

## Requirements
- R1: Synchronous active-low reset sets fetch_kind to 0 (idle), fetch_a12 to 0, line_count to 0 and irq to 0.
- R2: fetch_kind uses these codes: 0 idle, 1 name-table, 2 attribute, 3 pattern low, 4 pattern high. In dots 1..256 and 321..336, the phase is (dot-1) mod 8. Phases 0-1 give code 1, phases 2-3 give code 2, phases 4-5 give code 3 and phases 6-7 give code 4.
- R3: Dots 257..320 follow the same eight-dot phase order. Dots 257-258 are a dummy name-table fetch, dots 259-260 a dummy attribute fetch, and the first pattern-low fetch of the sprite region is at dots 261-262.
- R4: Dots 337..340 report name-table (1). Dot 0 and any dot above 340 report idle (0).
- R5: fetch_a12 equals bg_page during pattern fetches in dots 1..256 and 321..336, and equals spr_page during pattern fetches in dots 257..320. It is 0 in every other slot.
- R6: Outputs take the decode of dot one clock after an edge at which dot_en is high. While dot_en is low, fetch_kind, fetch_a12 and line_count hold.
- R7: While render_en is low, fetch_kind is idle, fetch_a12 is low and line_count does not change.
- R8: line_count changes only on a 0-to-1 transition of fetch_a12. On that step it reloads from reload_val if it is zero, and otherwise decrements by one.
- R9: irq is set by a step that leaves line_count at zero while irq_en is high. It stays set while irq_en stays high, and it is cleared and held low while irq_en is low.
- R10: With bg_page=0 and spr_page=1, the first rise of fetch_a12 on a line follows dot 261, and a full line produces exactly 8 counter steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dot_en | input | 1 | Dot strobe: sample dot on this edge |
| dot | input | 9 | Current dot index, 0..340 |
| render_en | input | 1 | Rendering enabled |
| bg_page | input | 1 | Background pattern page (0: $0000, 1: $1000) |
| spr_page | input | 1 | Sprite pattern page (0: $0000, 1: $1000) |
| irq_en | input | 1 | Interrupt enable; low clears irq |
| reload_val | input | 8 | Counter reload value |
| fetch_kind | output | 3 | Current fetch type code |
| fetch_a12 | output | 1 | Address line 12 level |
| line_count | output | 8 | Edge-clocked counter value |
| irq | output | 1 | Interrupt flag |

## Verification
The assertions take for granted that reset is applied from time zero and that dot, render_en and the page bits are meaningful whenever dot_en is high. They also take for granted that reload_val and irq_en are steady around a counter step. The bench keeps within this by changing all inputs only on the falling clock edge. It changes reload_val and irq_en only at line boundaries or on idle dots, where no rise of address line 12 can occur. The bench steps dots 0 to 340 once for each page combination, and once more with rendering off. A reference counter in the bench, driven by the arithmetically predicted level of address line 12, supplies the expected count and interrupt state.

// File: rtl/sfs_pkg.sv
// Shared fetch-type codes for the scanline fetch scheduler.
package sfs_pkg;
    localparam int KIND_W = 3;
    typedef logic [KIND_W-1:0] kind_t;
    localparam kind_t K_IDLE = 3'd0;
    localparam kind_t K_NT   = 3'd1;
    localparam kind_t K_AT   = 3'd2;
    localparam kind_t K_PLO  = 3'd3;
    localparam kind_t K_PHI  = 3'd4;
endpackage

// File: rtl/sfs_slot_decode.sv
// Combinational dot-to-fetch decoder.
// Maps a 1-based dot index onto the fetch type and the address line 12
// level. Assumes dot counts from 0 and never exceeds the line length.
module sfs_slot_decode
    import sfs_pkg::*;
#(
    parameter int DOT_W    = 9,
    parameter int BG_END   = 256,
    parameter int SPR_END  = 320,
    parameter int PRE_END  = 336,
    parameter int LAST_DOT = 340
) (
    input  logic [DOT_W-1:0] dot,
    input  logic             render_en,
    input  logic             bg_page,
    input  logic             spr_page,
    output kind_t            kind,
    output logic             a12
);
    localparam int SPR_START = BG_END + 1;
    localparam int PRE_START = SPR_END + 1;

    logic [2:0] phase;
    logic       in_bg, in_spr, in_tail;
    logic       page;

    // Region classification and in-group phase.
    always_comb begin
        phase   = 3'(dot - DOT_W'(1));
        in_bg   = ((dot >= DOT_W'(1)) && (dot <= DOT_W'(BG_END))) ||
                  ((dot >= DOT_W'(PRE_START)) && (dot <= DOT_W'(PRE_END)));
        in_spr  = (dot >= DOT_W'(SPR_START)) && (dot <= DOT_W'(SPR_END));
        in_tail = (dot > DOT_W'(PRE_END)) && (dot <= DOT_W'(LAST_DOT));
        page    = in_spr ? spr_page : bg_page;
    end

    // Fetch type and address line 12 selection.
    always_comb begin
        kind = K_IDLE;
        if (render_en) begin
            if (in_bg || in_spr) begin
                case (phase[2:1])
                    2'd0:    kind = K_NT;
                    2'd1:    kind = K_AT;
                    2'd2:    kind = K_PLO;
                    default: kind = K_PHI;
                endcase
            end else if (in_tail) begin
                kind = K_NT;
            end
        end
        a12 = ((kind == K_PLO) || (kind == K_PHI)) && page;
    end
endmodule

// File: rtl/sfs_edge_counter.sv
// Counter clocked by rising edges of address line 12.
// On a step it reloads when zero and otherwise decrements. irq is set when a
// step leaves it at zero with irq_en high, and it is cleared while irq_en is low.
// Assumes step is a single-cycle pulse.
module sfs_edge_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             irq_en,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] count,
    output logic             irq
);
    logic [CNT_W-1:0] count_nxt;

    // Next count on a step.
    always_comb begin
        count_nxt = (count == '0) ? reload_val : count - CNT_W'(1);
    end

    // Counter and interrupt flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            irq   <= 1'b0;
        end else begin
            if (step) count <= count_nxt;
            if (!irq_en) irq <= 1'b0;
            else if (step && (count_nxt == '0)) irq <= 1'b1;
        end
    end
endmodule

// File: rtl/scanline_fetch_sched.sv
// Scanline fetch scheduler top.
// Registers the decoded fetch type and address line 12 on each dot strobe,
// and steps the edge counter when address line 12 goes from 0 to 1.
// Assumes inputs are stable around the sampling edge.
module scanline_fetch_sched
    import sfs_pkg::*;
#(
    parameter int DOT_W    = 9,
    parameter int CNT_W    = 8,
    parameter int BG_END   = 256,
    parameter int SPR_END  = 320,
    parameter int PRE_END  = 336,
    parameter int LAST_DOT = 340
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dot_en,
    input  logic [DOT_W-1:0] dot,
    input  logic             render_en,
    input  logic             bg_page,
    input  logic             spr_page,
    input  logic             irq_en,
    input  logic [CNT_W-1:0] reload_val,
    output logic [KIND_W-1:0] fetch_kind,
    output logic             fetch_a12,
    output logic [CNT_W-1:0] line_count,
    output logic             irq
);
    kind_t kind_d;
    logic  a12_d;
    logic  rise;

    sfs_slot_decode #(
        .DOT_W(DOT_W), .BG_END(BG_END), .SPR_END(SPR_END),
        .PRE_END(PRE_END), .LAST_DOT(LAST_DOT)
    ) u_dec (
        .dot(dot), .render_en(render_en), .bg_page(bg_page),
        .spr_page(spr_page), .kind(kind_d), .a12(a12_d)
    );

    // Rising edge of address line 12 as it is about to be registered.
    always_comb rise = dot_en && a12_d && !fetch_a12;

    // Output registers for fetch type and address line 12.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_kind <= K_IDLE;
            fetch_a12  <= 1'b0;
        end else if (dot_en) begin
            fetch_kind <= kind_d;
            fetch_a12  <= a12_d;
        end
    end

    sfs_edge_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .step(rise), .irq_en(irq_en),
        .reload_val(reload_val), .count(line_count), .irq(irq)
    );
endmodule

// File: rtl/sfs_checker.sv
// Assertion checker for the scanline fetch scheduler, bound to the top.
module sfs_checker #(
    parameter int DOT_W = 9,
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dot_en,
    input logic [DOT_W-1:0] dot,
    input logic             render_en,
    input logic             irq_en,
    input logic [2:0]       fetch_kind,
    input logic             fetch_a12,
    input logic [CNT_W-1:0] line_count,
    input logic             irq
);
    a_r6_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !dot_en |=> ($stable(fetch_kind) && $stable(fetch_a12) && $stable(line_count)));

    a_r7_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (dot_en && !render_en) |=> (fetch_kind == 3'd0 && !fetch_a12));

    a_r5_a12_only_in_pattern: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_a12 |-> (fetch_kind == 3'd3 || fetch_kind == 3'd4));

    a_r8_count_on_rise_only: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(line_count) |-> $rose(fetch_a12));

    a_r9_irq_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |=> !irq);

    a_r9_irq_needs_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (line_count == '0));

    a_r2_kind_legal: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_kind <= 3'd4);
endmodule

bind scanline_fetch_sched sfs_checker #(.DOT_W(DOT_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .dot_en(dot_en), .dot(dot),
    .render_en(render_en), .irq_en(irq_en), .fetch_kind(fetch_kind),
    .fetch_a12(fetch_a12), .line_count(line_count), .irq(irq)
);

// File: tb/sim_scanline_fetch_sched.sv
module sim_scanline_fetch_sched;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dot_en = 1'b0;
    logic [8:0] dot = '0;
    logic       render_en = 1'b0;
    logic       bg_page = 1'b0;
    logic       spr_page = 1'b0;
    logic       irq_en = 1'b0;
    logic [7:0] reload_val = '0;
    logic [2:0] fetch_kind;
    logic       fetch_a12;
    logic [7:0] line_count;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model state
    logic       ref_a12 = 1'b0;
    logic [7:0] ref_cnt = '0;
    logic       ref_irq = 1'b0;
    int         rises = 0;
    int         first_rise = -1;

    always #5 clk = ~clk;

    scanline_fetch_sched u0 (
        .clk(clk), .rst_n(rst_n), .dot_en(dot_en), .dot(dot),
        .render_en(render_en), .bg_page(bg_page), .spr_page(spr_page),
        .irq_en(irq_en), .reload_val(reload_val), .fetch_kind(fetch_kind),
        .fetch_a12(fetch_a12), .line_count(line_count), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp, input int d);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s dot=%0d actual=%0d expected=%0d", req, d, act, exp);
        end
    endtask

    // Expected fetch code from the R2/R3/R4 schedule.
    function automatic int exp_kind(input int d, input bit ren);
        if (!ren || d == 0 || d > 340) return 0;
        if (d >= 337) return 1;
        return ((d - 1) % 8) / 2 + 1;
    endfunction

    // Expected address line 12 per R5.
    function automatic bit exp_a12(input int d, input bit ren, input bit bp, input bit sp);
        int k;
        k = exp_kind(d, ren);
        if (k < 3) return 1'b0;
        return (d >= 257 && d <= 320) ? sp : bp;
    endfunction

    // Apply one dot with the strobe high and check the registered result.
    task automatic step(input int d);
        int  k;
        bit  a;
        dot    = 9'(d);
        dot_en = 1'b1;
        k = exp_kind(d, render_en);
        a = exp_a12(d, render_en, bg_page, spr_page);
        if (a && !ref_a12) begin
            ref_cnt = (ref_cnt == 0) ? reload_val : ref_cnt - 8'd1;
            rises++;
            if (first_rise < 0) first_rise = d;
            if (irq_en && ref_cnt == 0) ref_irq = 1'b1;
        end
        if (!irq_en) ref_irq = 1'b0;
        ref_a12 = a;
        @(negedge clk);
        if (d >= 257 && d <= 320) chk("R3", fetch_kind, k, d);
        else if (d == 0 || d >= 337) chk("R4", fetch_kind, k, d);
        else chk("R2", fetch_kind, k, d);
        chk("R5", fetch_a12, a, d);
        chk("R8", line_count, ref_cnt, d);
        chk("R9", irq, ref_irq, d);
    endtask

    task automatic sweep_line();
        rises = 0;
        first_rise = -1;
        for (int d = 0; d <= 340; d++) step(d);
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1", fetch_kind, 0, 0);
        chk("R1", fetch_a12, 0, 0);
        chk("R1", line_count, 0, 0);
        chk("R1", irq, 0, 0);
        rst_n = 1'b1;
        irq_en = 1'b1;
        reload_val = 8'd5;
        render_en = 1'b1;

        // R10: bg at $0000, sprites at $1000
        bg_page = 1'b0; spr_page = 1'b1;
        sweep_line();
        chk("R10", first_rise, 261, 261);
        chk("R10", rises, 8, 0);

        // All other page combinations (R2, R5, R8)
        for (int c = 0; c < 4; c++) begin
            bg_page = c[0]; spr_page = c[1];
            if (c == 2) reload_val = 8'd3;
            sweep_line();
            chk("R8", rises, (c[0] ? 34 : 0) + (c[1] ? 8 : 0) - ((c == 3) ? 0 : 0), c);
        end

        // R9: disable interrupts at an idle dot, then sweep once more
        irq_en = 1'b0;
        step(0);
        chk("R9", irq, 0, 0);
        bg_page = 1'b1; spr_page = 1'b1;
        sweep_line();
        irq_en = 1'b1;

        // R7: rendering off sweeps keep everything quiet
        render_en = 1'b0;
        sweep_line();
        chk("R7", rises, 0, 0);
        render_en = 1'b1;

        // R6: strobe low holds outputs while dot moves to a pattern slot
        step(262);
        dot_en = 1'b0;
        dot = 9'd265;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R6", fetch_kind, 3, 265);
            chk("R6", fetch_a12, 1, 265);
            chk("R6", line_count, ref_cnt, 265);
        end
        step(265);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule